// File: doc/BRIEF.md
# Half-Duplex Programming Frame Transceiver

This block is the host end of a clocked programming link that carries data on a single line. The host generates the link clock. On a send strobe it shifts one byte out as a framed character. On a receive strobe it holds the outgoing line high, lets the target answer, and captures one framed character. It then reports either the byte or an error class.

The link clock comes from a divider in the system clock domain. Every link bit lasts one link-clock period: `HALF_CYC` system cycles with the link clock low, then `HALF_CYC` system cycles with it high. A frame has one low start bit, eight data bits sent least-significant first, an even-parity bit, and two high stop bits. Command sequencing, target reset control and delay calibration are left to the logic around the block.

Top module: `pframe_xcvr`

## Requirements
- R1: After reset and whenever no operation is running, `link_clk` is 0, `link_dout` is 1, `busy` is 0, `rx_valid` and `rx_err` are 0, and `rx_byte` and `rx_err_kind` are 0 straight after reset.
- R2: An accepted send puts out 12 link bits on `link_dout`: bit 0 is 0, bits 1 to 8 are `tx_byte[0]` to `tx_byte[7]`, and bits 10 and 11 are 1. `busy` stays high for exactly 24*`HALF_CYC` cycles, starting the cycle after the strobe.
- R3: Link bit 9 of a sent frame is the XOR of the eight data bits.
- R4: In every link bit, `link_clk` is low for `HALF_CYC` cycles and then high for `HALF_CYC` cycles. `link_dout` changes only on the edge where `link_clk` falls or stays low.
- R5: During a receive, `link_dout` stays at 1 for the whole operation.
- R6: `link_din` is sampled on the last system cycle of each high phase of `link_clk`. The eight bits after the start bit are assembled least-significant first into `rx_byte`.
- R7: The receiver takes at most 10 samples while looking for a low start bit. If all 10 are high, it ends with `rx_err` and `rx_err_kind` = 2'b01.
- R8: If the sample after the eight data bits differs from their XOR, the receive ends right after that bit with `rx_err` and `rx_err_kind` = 2'b10.
- R9: If either of the two samples after the parity bit is low, the receive ends after both of them with `rx_err` and `rx_err_kind` = 2'b11.
- R10: A send or receive strobe seen while `busy` is 1 is ignored, including in the last busy cycle.
- R11: If send and receive strobes arrive together while idle, the send is performed.
- R12: `rx_valid` (good frame, `rx_err_kind` set to 2'b00) or `rx_err` is high for exactly one cycle: the first cycle after `busy` falls at the end of a receive. `rx_byte` keeps its value until the next good frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_byte | input | 8 | Byte to send, taken with the send strobe |
| send_req | input | 1 | Send strobe |
| recv_req | input | 1 | Receive strobe |
| rx_byte | output | 8 | Last byte received without error |
| rx_valid | output | 1 | One-cycle pulse for a good received frame |
| rx_err | output | 1 | One-cycle pulse for a failed receive |
| rx_err_kind | output | 2 | 00 good, 01 no start bit, 10 parity, 11 stop bit |
| busy | output | 1 | Operation in progress |
| link_clk | output | 1 | Link clock to the target |
| link_dout | output | 1 | Outgoing data line |
| link_din | input | 1 | Incoming data line |

## Verification
Two functions can fall in the same cycle. The first is the arrival of a new strobe in the cycle where a frame finishes. The bench raises a strobe exactly in the last busy cycle and expects it to be dropped, then raises one in the first idle cycle and expects it to start a frame. The second is a send and a receive requested together: the bench asserts both strobes in one idle cycle and checks that the line carries a transmit frame and that neither `rx_valid` nor `rx_err` follows. A behavioural model built from queues checks every output on every clock, so a stray pulse or a stretched busy shows up in the cycle where it happens.

// File: rtl/pframe_pkg.sv
package pframe_pkg;

  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = 12;
  localparam int IDX_W      = 4;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'b00,
    ERR_START  = 2'b01,
    ERR_PARITY = 2'b10,
    ERR_STOP   = 2'b11
  } rx_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX,
    ST_HUNT,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } eng_st_e;

  // even parity over a data byte
  function automatic logic even_par(input logic [DATA_BITS-1:0] b);
    return ^b;
  endfunction

  // line level of link bit idx in an outgoing frame
  function automatic logic tx_line_bit(input logic [DATA_BITS-1:0] b,
                                       input logic [IDX_W-1:0] idx);
    logic v;
    if (idx == '0)                             v = 1'b0;
    else if (idx <= IDX_W'(DATA_BITS))         v = b[3'(idx - 4'd1)];
    else if (idx == IDX_W'(DATA_BITS + 1))     v = even_par(b);
    else                                       v = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/pframe_clkgen.sv
module pframe_clkgen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pframe_engine.sv
module pframe_engine
  import pframe_pkg::*;
#(
  parameter int HUNT_WIN = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 send_req,
  input  logic                 recv_req,
  input  logic [DATA_BITS-1:0] tx_byte,
  input  logic                 line_in,
  output logic                 sclk,
  output logic                 line_out,
  output logic                 busy,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 rx_err,
  output rx_err_e              err_kind,
  output logic                 rx_mode,
  output logic                 fall
);
  localparam int HW = $clog2(HUNT_WIN + 1);

  eng_st_e              st;
  logic [IDX_W-1:0]     bit_idx;
  logic [HW-1:0]        hunt_cnt;
  logic [DATA_BITS-1:0] shreg;
  logic [DATA_BITS-1:0] tx_hold;
  logic                 stop_ok;
  logic                 rise;

  assign busy    = (st != ST_IDLE);
  assign rx_mode = (st == ST_HUNT) || (st == ST_DATA) || (st == ST_PAR) || (st == ST_STOP);
  assign rise    = tick && !sclk;
  assign fall    = tick && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sclk     <= 1'b0;
      line_out <= 1'b1;
      bit_idx  <= '0;
      hunt_cnt <= '0;
      shreg    <= '0;
      tx_hold  <= '0;
      stop_ok  <= 1'b1;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      err_kind <= ERR_NONE;
    end else begin
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      if (st == ST_IDLE) begin
        if (send_req) begin
          tx_hold  <= tx_byte;
          bit_idx  <= '0;
          line_out <= tx_line_bit(tx_byte, '0);
          st       <= ST_TX;
        end else if (recv_req) begin
          line_out <= 1'b1;
          hunt_cnt <= '0;
          st       <= ST_HUNT;
        end
      end else if (rise) begin
        sclk <= 1'b1;
      end else if (fall) begin
        sclk <= 1'b0;
        case (st)
          ST_TX: begin
            if (bit_idx == IDX_W'(FRAME_BITS - 1)) begin
              st <= ST_IDLE;
            end else begin
              bit_idx  <= bit_idx + 1'b1;
              line_out <= tx_line_bit(tx_hold, bit_idx + 1'b1);
            end
          end
          ST_HUNT: begin
            if (!line_in) begin
              st      <= ST_DATA;
              bit_idx <= '0;
            end else if (hunt_cnt == HW'(HUNT_WIN - 1)) begin
              st       <= ST_IDLE;
              rx_err   <= 1'b1;
              err_kind <= ERR_START;
            end else begin
              hunt_cnt <= hunt_cnt + 1'b1;
            end
          end
          ST_DATA: begin
            shreg <= {line_in, shreg[DATA_BITS-1:1]};
            if (bit_idx == IDX_W'(DATA_BITS - 1)) st <= ST_PAR;
            else                                  bit_idx <= bit_idx + 1'b1;
          end
          ST_PAR: begin
            if (line_in != even_par(shreg)) begin
              st       <= ST_IDLE;
              rx_err   <= 1'b1;
              err_kind <= ERR_PARITY;
            end else begin
              st      <= ST_STOP;
              bit_idx <= '0;
            end
          end
          ST_STOP: begin
            if (bit_idx == '0) begin
              stop_ok <= line_in;
              bit_idx <= 1;
            end else begin
              st <= ST_IDLE;
              if (stop_ok && line_in) begin
                rx_valid <= 1'b1;
                rx_byte  <= shreg;
                err_kind <= ERR_NONE;
              end else begin
                rx_err   <= 1'b1;
                err_kind <= ERR_STOP;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pframe_xcvr.sv
module pframe_xcvr
  import pframe_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int HUNT_WIN = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_byte,
  input  logic       send_req,
  input  logic       recv_req,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       rx_err,
  output logic [1:0] rx_err_kind,
  output logic       busy,
  output logic       link_clk,
  output logic       link_dout,
  input  logic       link_din
);
  logic    tick;
  logic    rx_mode;
  logic    fall;
  rx_err_e kind;

  pframe_clkgen #(.HALF_CYC(HALF_CYC)) u_clkgen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  pframe_engine #(.HUNT_WIN(HUNT_WIN)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .send_req(send_req),
    .recv_req(recv_req),
    .tx_byte (tx_byte),
    .line_in (link_din),
    .sclk    (link_clk),
    .line_out(link_dout),
    .busy    (busy),
    .rx_byte (rx_byte),
    .rx_valid(rx_valid),
    .rx_err  (rx_err),
    .err_kind(kind),
    .rx_mode (rx_mode),
    .fall    (fall)
  );

  assign rx_err_kind = kind;
endmodule

// File: rtl/pframe_xcvr_chk.sv
module pframe_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic link_clk,
  input logic link_dout,
  input logic rx_valid,
  input logic rx_err,
  input logic rx_mode,
  input logic fall,
  input logic send_req,
  input logic recv_req
);
  p_idle_clk_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !link_clk);

  p_dout_moves_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(link_dout) |-> !link_clk);

  p_rx_line_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode |-> link_dout);

  p_no_hijack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode && send_req) |=> (rx_mode || !busy));

  p_send_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && send_req && recv_req) |=> (busy && !rx_mode));

  p_pulse_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || rx_err) |=> !(rx_valid || rx_err));

  p_pulse_at_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || rx_err) |-> (!busy && $past(busy) && $past(fall)));

  p_pulse_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_err));
endmodule

bind pframe_xcvr pframe_xcvr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .link_clk (link_clk),
  .link_dout(link_dout),
  .rx_valid (rx_valid),
  .rx_err   (rx_err),
  .rx_mode  (rx_mode),
  .fall     (fall),
  .send_req (send_req),
  .recv_req (recv_req)
);

// File: tb/pframe_xcvr_bench.sv
module pframe_xcvr_bench;
  localparam int H   = 3;
  localparam int WIN = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       send_req = 1'b0;
  logic       recv_req = 1'b0;
  logic       link_din = 1'b1;
  logic [7:0] rx_byte;
  logic       rx_valid, rx_err, busy, link_clk, link_dout;
  logic [1:0] rx_err_kind;

  pframe_xcvr #(.HALF_CYC(H), .HUNT_WIN(WIN)) u_pframe_xcvr (
    .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .send_req(send_req),
    .recv_req(recv_req), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_err(rx_err), .rx_err_kind(rx_err_kind), .busy(busy),
    .link_clk(link_clk), .link_dout(link_dout), .link_din(link_din));

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  string ttag = "R1";

  // reference model state
  bit   qc[$];
  bit   qd[$];
  int   pl[32];
  int   elapsed = 0;
  bit   in_rx = 0;
  bit   pend_ok = 0;
  int   pend_kind = 0;
  int   pend_byte = 0;
  bit   exp_v = 0, exp_e = 0;
  int   exp_byte = 0, exp_kind = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", ttag, what, act, exp, $time);
    end
  endtask

  task automatic push_bits(input int n, input int lvl[32]);
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < H; j++) begin qc.push_back(1'b0); qd.push_back(lvl[k][0]); end
      for (int j = 0; j < H; j++) begin qc.push_back(1'b1); qd.push_back(lvl[k][0]); end
    end
  endtask

  task automatic build_tx(input int b);
    int lvl[32];
    int ones = 0;
    for (int k = 0; k < 32; k++) lvl[k] = 1;
    lvl[0] = 0;
    for (int k = 0; k < 8; k++) begin
      lvl[k+1] = (b >> k) & 1;
      ones += lvl[k+1];
    end
    lvl[9] = ones % 2;
    push_bits(12, lvl);
    in_rx = 0;
  endtask

  task automatic build_rx();
    int lvl[32];
    int s = -1;
    int n;
    int ones = 0;
    int by = 0;
    for (int k = 0; k < 32; k++) lvl[k] = 1;
    for (int k = 0; k < WIN; k++) if (s < 0 && pl[k] == 0) s = k;
    if (s < 0) begin
      n = WIN; pend_ok = 0; pend_kind = 1;
    end else begin
      for (int j = 0; j < 8; j++) begin
        by += pl[s+1+j] << j;
        ones += pl[s+1+j];
      end
      if (pl[s+9] != ones % 2) begin
        n = s + 10; pend_ok = 0; pend_kind = 2;
      end else begin
        n = s + 12;
        if (pl[s+10] == 1 && pl[s+11] == 1) begin pend_ok = 1; pend_kind = 0; pend_byte = by; end
        else begin pend_ok = 0; pend_kind = 3; end
      end
    end
    push_bits(n, lvl);
    in_rx = 1;
  endtask

  always @(posedge clk) begin
    exp_v = 0; exp_e = 0;
    if (!rst_n) begin
      qc.delete(); qd.delete(); elapsed = 0; in_rx = 0;
      exp_byte = 0; exp_kind = 0;
    end else if (qc.size() == 0) begin
      elapsed = 0;
      if (send_req) build_tx(tx_byte);
      else if (recv_req) build_rx();
    end else begin
      void'(qc.pop_front()); void'(qd.pop_front());
      elapsed++;
      if (qc.size() == 0 && in_rx) begin
        in_rx = 0;
        if (pend_ok) begin exp_v = 1; exp_byte = pend_byte; exp_kind = 0; end
        else begin exp_e = 1; exp_kind = pend_kind; end
      end
    end
  end

  // compare every cycle, then play the target's answer
  int cyc = 0;
  always @(negedge clk) begin
    bit ec, ed, eb;
    cyc++;
    ec = (qc.size() > 0) ? qc[0] : 1'b0;
    ed = (qd.size() > 0) ? qd[0] : 1'b1;
    eb = (qc.size() > 0);
    chk(link_clk == ec, "R4 link_clk", link_clk, ec);
    chk(link_dout == ed, in_rx ? "R5 link_dout" : "R2/R3 link_dout", link_dout, ed);
    chk(busy == eb, "R2/R10 busy", busy, eb);
    chk(rx_valid == exp_v, "R12 rx_valid", rx_valid, exp_v);
    chk(rx_err == exp_e, "R12 rx_err", rx_err, exp_e);
    chk(rx_byte == 8'(exp_byte), "R6 rx_byte", rx_byte, exp_byte);
    chk(rx_err_kind == 2'(exp_kind), "R7/R8/R9 rx_err_kind", rx_err_kind, exp_kind);
    link_din = (in_rx && qc.size() > 0 && elapsed / (2*H) < 32) ? pl[elapsed / (2*H)][0] : 1'b1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic strobe(input bit s, input bit r, input int b);
    @(negedge clk);
    #1;
    tx_byte = 8'(b); send_req = s; recv_req = r;
    @(negedge clk);
    #1;
    send_req = 0; recv_req = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (qc.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic plan(input int s, input int b, input int pflip, input int st1, input int st2);
    int ones = 0;
    for (int k = 0; k < 32; k++) pl[k] = 1;
    if (s >= 0) begin
      pl[s] = 0;
      for (int j = 0; j < 8; j++) begin pl[s+1+j] = (b >> j) & 1; ones += pl[s+1+j]; end
      pl[s+9] = (ones % 2) ^ pflip;
      pl[s+10] = st1; pl[s+11] = st2;
    end
  endtask

  initial begin
    for (int k = 0; k < 32; k++) pl[k] = 1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R2 R3 R4: several transmit patterns
    ttag = "R2/R3";
    strobe(1, 0, 8'hA5); wait_idle();
    strobe(1, 0, 8'h00); wait_idle();
    strobe(1, 0, 8'hFF); wait_idle();
    strobe(1, 0, 8'h3C); wait_idle();
    // R6: good receives at different start offsets, R7 limit at last slot
    ttag = "R6";
    plan(0, 8'h5A, 0, 1, 1); strobe(0, 1, 0); wait_idle();
    plan(3, 8'hC3, 0, 1, 1); strobe(0, 1, 0); wait_idle();
    ttag = "R7";
    plan(9, 8'h81, 0, 1, 1); strobe(0, 1, 0); wait_idle();
    plan(-1, 0, 0, 1, 1); strobe(0, 1, 0); wait_idle();
    ttag = "R8";
    plan(2, 8'h17, 1, 1, 1); strobe(0, 1, 0); wait_idle();
    ttag = "R9";
    plan(1, 8'h6E, 0, 0, 1); strobe(0, 1, 0); wait_idle();
    plan(1, 8'h6E, 0, 1, 0); strobe(0, 1, 0); wait_idle();
    // R10: strobes during an operation and in its last busy cycle
    ttag = "R10";
    plan(0, 8'h24, 0, 1, 1);
    strobe(1, 0, 8'h99);
    repeat (20) @(negedge clk);
    #1 recv_req = 1; send_req = 1;
    @(negedge clk); #1 recv_req = 0; send_req = 0;
    while (qc.size() != 1) @(negedge clk);
    #1 send_req = 1; tx_byte = 8'h11;
    @(negedge clk); #1 send_req = 0;
    repeat (3) @(negedge clk);
    // back-to-back: strobe in first idle cycle is taken
    strobe(0, 1, 0);
    repeat (30) @(negedge clk);
    #1 send_req = 1; tx_byte = 8'h42;
    @(negedge clk); #1 send_req = 0;
    while (qc.size() != 1) @(negedge clk);
    @(negedge clk); #1 send_req = 1; tx_byte = 8'h7E;
    @(negedge clk); #1 send_req = 0;
    wait_idle();
    // R11: both strobes together while idle
    ttag = "R11";
    plan(0, 8'h55, 0, 1, 1);
    strobe(1, 1, 8'hE1); wait_idle();
    ttag = "R12";
    plan(4, 8'hB2, 0, 1, 1); strobe(0, 1, 0); wait_idle();
    ttag = "R1";
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule